// File: doc/BRIEF.md
# Burst SRAM Cycle Decoder

This block sits at the control edge of a synchronous burst SRAM. On every rising clock edge it samples the chip enables, the two address strobes, the advance strobe, the write inputs and the sleep request. From these it picks one of six cycle kinds. The result is registered as a one-hot vector. Next to it the block produces the flags that a burst address counter and the storage array use: load a new address, step the burst, write this beat, read this beat.

The merged write request is formed combinationally from the global write, the byte-write master enable and the per-byte enables. The block also tracks whether a burst session is open. A session is opened by a started read or write and closed by a deselect or sleep cycle. Continuation cycles move data only while a session is open. The data-bus output enable is not clocked. It follows the output-enable pin combinationally, but only while the registered cycle is a read beat. This masks it during write beats.

The processor strobe always begins a read, whatever the write inputs say. A write can begin only from the controller strobe, or happen as a continuation beat after a start.

Top module: `sram_cycle_decoder`

## Requirements
- R1: When `sleep_req` is 1 at an edge, `cyc_q` becomes bit 1 (sleep) after that edge and all other inputs are ignored: `wr_q`, `rd_q`, `burst_load`, `burst_step` are 0 and the session closes.
- R2: When either strobe is low and the device is not selected, `cyc_q` becomes bit 0 (deselect) and the session closes. The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0.
- R3: A selected cycle with `adsp_n`=0 gives `cyc_q` bit 2 (read begin), `rd_q`=1, `burst_load`=1 and `wr_q`=0, even when the write request is active.
- R4: A selected cycle with `adsp_n`=1, `adsc_n`=0 and the write request active gives `cyc_q` bit 3 (write begin), `wr_q`=1 and `burst_load`=1.
- R5: A selected cycle with `adsp_n`=1, `adsc_n`=0 and no write request gives `cyc_q` bit 2 with `rd_q`=1.
- R6: `wr_strobe` is 1 when `gw_n`=0, or when `bwe_n`=0 and at least one bit of `bw_n` is 0. It is 0 otherwise.
- R7: With both strobes high and `sleep_req`=0, `cyc_q` is bit 4 (continue) when `adv_n`=0 and bit 5 (suspend) when `adv_n`=1. `burst_step` is 1 only for a continue cycle inside an open session.
- R8: In a continue or suspend cycle inside an open session, `wr_q` equals the write request and `rd_q` is its inverse. Outside a session both are 0, and the session state is kept.
- R9: `dq_oe` equals `rd_q` AND NOT `oe_n`, changes with `oe_n` without a clock, and is 0 whenever `wr_q` is 1.
- R10: While `rst_n` is 0, at the next edge `cyc_q` becomes bit 0, every flag becomes 0 and the session closes.
- R11: `cyc_q` has exactly one bit set at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_req | input | 1 | Sleep request, active high |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| bw_n | input | NUM_BYTES | Per-byte write enables, active low |
| bwe_n | input | 1 | Byte-write master enable, active low |
| gw_n | input | 1 | Global write, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| wr_strobe | output | 1 | Merged write request (combinational) |
| cyc_q | output | 6 | Registered one-hot cycle kind |
| wr_q | output | 1 | Registered write-beat flag |
| rd_q | output | 1 | Registered read-beat flag |
| burst_load | output | 1 | Registered: load external address |
| burst_step | output | 1 | Registered: advance burst counter |
| dq_oe | output | 1 | Data-bus output driver enable |

## Verification
Some properties hold on every cycle, and the assertions cover these. The cycle vector is always one-hot. A sleep cycle raises no data flag. Read and write flags never coincide. The output driver is never on during a write beat. A processor-strobe start or an unselected strobe always leads to the right cycle kind on the next edge. The priority order itself, and the way the session state decides whether a continuation moves data, can only be shown by the bench. It sweeps every control combination from both an open and a closed session and compares each against values it computes itself. That sweep is also what exposes a wrongly merged write request or an output enable that ignores its pin.

// File: rtl/sram_cyc_pkg.sv
// Package: shared cycle-kind encoding and helpers for the burst SRAM
// cycle decoder. Assumes six cycle kinds, one-hot encoded by enum value.
package sram_cyc_pkg;

    localparam int CYC_W = 6;

    typedef enum logic [2:0] {
        CYC_DESEL    = 3'd0,
        CYC_SLEEP    = 3'd1,
        CYC_RD_BEGIN = 3'd2,
        CYC_WR_BEGIN = 3'd3,
        CYC_CONT     = 3'd4,
        CYC_SUSP     = 3'd5
    } cyc_kind_e;

    // Sampled control view handed to the classifier.
    typedef struct packed {
        logic sleep;
        logic strobe_p;
        logic strobe_c;
        logic selected;
        logic advance;
        logic wr_req;
    } ctl_t;

    // Next-state bundle produced by the classifier.
    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic             wr;
        logic             rd;
        logic             load;
        logic             step;
        logic             sess;
    } nxt_t;

    function automatic logic [CYC_W-1:0] kind_to_onehot(input cyc_kind_e k);
        return CYC_W'(1) << k;
    endfunction

endpackage

// File: rtl/sram_wr_combine.sv
// Module: merges global write, byte-write master enable and per-byte
// enables into one active-high write request. Assumes active-low inputs;
// the per-byte OR is built as a generated chain sized by NUM_BYTES.
module sram_wr_combine #(
    parameter int NUM_BYTES = 4
) (
    input  logic [NUM_BYTES-1:0] bw_n,
    input  logic                 bwe_n,
    input  logic                 gw_n,
    output logic                 wr_req
);
    logic [NUM_BYTES:0] any_byte;

    assign any_byte[0] = 1'b0;

    // Accumulate "some byte lane enabled" lane by lane.
    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_lane
        assign any_byte[gi+1] = any_byte[gi] | ~bw_n[gi];
    end

    // Global write wins; otherwise master enable plus any lane.
    assign wr_req = ~gw_n | (~bwe_n & any_byte[NUM_BYTES]);

endmodule

// File: rtl/sram_cyc_classify.sv
// Module: combinational cycle classifier. Applies the priority
// sleep > strobe decode (deselect / read begin / write begin) >
// continuation (continue / suspend) and derives the next flags and
// session state. Assumes the session flag reflects the previous edge.
module sram_cyc_classify
    import sram_cyc_pkg::*;
(
    input  ctl_t ctl,
    input  logic sess_q,
    output nxt_t nxt
);
    cyc_kind_e kind;
    logic      is_cont;

    // Pick the cycle kind by fixed priority.
    always_comb begin
        if (ctl.sleep)
            kind = CYC_SLEEP;
        else if (ctl.strobe_p || ctl.strobe_c) begin
            if (!ctl.selected)
                kind = CYC_DESEL;
            else if (ctl.strobe_p)
                kind = CYC_RD_BEGIN;
            else if (ctl.wr_req)
                kind = CYC_WR_BEGIN;
            else
                kind = CYC_RD_BEGIN;
        end else if (ctl.advance)
            kind = CYC_CONT;
        else
            kind = CYC_SUSP;
    end

    assign is_cont = (kind == CYC_CONT) || (kind == CYC_SUSP);

    // Derive flags and session state from the kind.
    always_comb begin
        nxt.cyc  = kind_to_onehot(kind);
        nxt.load = (kind == CYC_RD_BEGIN) || (kind == CYC_WR_BEGIN);
        nxt.wr   = (kind == CYC_WR_BEGIN) || (is_cont && sess_q && ctl.wr_req);
        nxt.rd   = (kind == CYC_RD_BEGIN) || (is_cont && sess_q && !ctl.wr_req);
        nxt.step = (kind == CYC_CONT) && sess_q;
        if (nxt.load)
            nxt.sess = 1'b1;
        else if (is_cont)
            nxt.sess = sess_q;
        else
            nxt.sess = 1'b0;
    end

endmodule

// File: rtl/sram_cyc_state.sv
// Module: registers the classifier result. Synchronous active-low reset
// returns the deselect kind with all flags and the session cleared.
module sram_cyc_state
    import sram_cyc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  nxt_t nxt,
    output nxt_t cur
);
    // Capture the decoded cycle on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur.cyc  <= kind_to_onehot(CYC_DESEL);
            cur.wr   <= 1'b0;
            cur.rd   <= 1'b0;
            cur.load <= 1'b0;
            cur.step <= 1'b0;
            cur.sess <= 1'b0;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/sram_cycle_decoder.sv
// Module: top of the burst SRAM cycle decoder. Samples control pins at
// each rising edge, registers a one-hot cycle kind plus burst/data flags,
// and gates the data-bus driver with the unclocked output enable.
// Assumes all control inputs are synchronous to clk except oe_n.
module sram_cycle_decoder
    import sram_cyc_pkg::*;
#(
    parameter int NUM_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_req,
    input  logic                 ce1_n,
    input  logic                 ce2,
    input  logic                 ce3_n,
    input  logic                 adsp_n,
    input  logic                 adsc_n,
    input  logic                 adv_n,
    input  logic [NUM_BYTES-1:0] bw_n,
    input  logic                 bwe_n,
    input  logic                 gw_n,
    input  logic                 oe_n,
    output logic                 wr_strobe,
    output logic [5:0]           cyc_q,
    output logic                 wr_q,
    output logic                 rd_q,
    output logic                 burst_load,
    output logic                 burst_step,
    output logic                 dq_oe
);
    ctl_t ctl;
    nxt_t nxt;
    nxt_t cur;
    logic wr_req;

    sram_wr_combine #(.NUM_BYTES(NUM_BYTES)) i_wr_combine (
        .bw_n   (bw_n),
        .bwe_n  (bwe_n),
        .gw_n   (gw_n),
        .wr_req (wr_req)
    );

    // Translate pin polarities into the classifier view.
    always_comb begin
        ctl.sleep    = sleep_req;
        ctl.strobe_p = ~adsp_n;
        ctl.strobe_c = ~adsc_n;
        ctl.selected = ~ce1_n & ce2 & ~ce3_n;
        ctl.advance  = ~adv_n;
        ctl.wr_req   = wr_req;
    end

    sram_cyc_classify i_classify (
        .ctl    (ctl),
        .sess_q (cur.sess),
        .nxt    (nxt)
    );

    sram_cyc_state i_state (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .cur   (cur)
    );

    // Drive registered results and the unclocked bus enable.
    always_comb begin
        wr_strobe  = wr_req;
        cyc_q      = cur.cyc;
        wr_q       = cur.wr;
        rd_q       = cur.rd;
        burst_load = cur.load;
        burst_step = cur.step;
        dq_oe      = cur.rd & ~oe_n;
    end

endmodule

// File: rtl/sram_cycle_decoder_chk.sv
// Checker: cycle-by-cycle properties of the burst SRAM cycle decoder,
// observed on its ports only. Bound to the top module below.
module sram_cycle_decoder_chk #(
    parameter int NUM_BYTES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sleep_req,
    input logic                 ce1_n,
    input logic                 ce2,
    input logic                 ce3_n,
    input logic                 adsp_n,
    input logic                 adsc_n,
    input logic [NUM_BYTES-1:0] bw_n,
    input logic [5:0]           cyc_q,
    input logic                 wr_q,
    input logic                 rd_q,
    input logic                 burst_load,
    input logic                 burst_step,
    input logic                 dq_oe
);
    AST_CYC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cyc_q) == 1); // R11

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_q[1] |-> !wr_q && !rd_q && !burst_load && !burst_step); // R1

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_q && rd_q)); // R8

    AST_OE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> !dq_oe); // R9

    AST_PSTROBE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_req && !adsp_n && !ce1_n && ce2 && !ce3_n)
        |=> (cyc_q[2] && rd_q && !wr_q)); // R3

    AST_UNSEL_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_req && (!adsp_n || !adsc_n) && (ce1_n || !ce2 || ce3_n))
        |=> cyc_q[0]); // R2

endmodule

bind sram_cycle_decoder sram_cycle_decoder_chk #(.NUM_BYTES(NUM_BYTES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_req  (sleep_req),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .adsp_n     (adsp_n),
    .adsc_n     (adsc_n),
    .bw_n       (bw_n),
    .cyc_q      (cyc_q),
    .wr_q       (wr_q),
    .rd_q       (rd_q),
    .burst_load (burst_load),
    .burst_step (burst_step),
    .dq_oe      (dq_oe)
);

// File: tb/test_sram_cycle_decoder.sv
// Bench: exhaustive sweep of all control combinations (2 byte lanes)
// from both a closed and an open burst session.
module test_sram_cycle_decoder;
    localparam int  NB     = 2;
    localparam time CLK_P  = 10;
    localparam int  WD_LIM = 50000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sleep_req, ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n;
    logic [NB-1:0] bw_n;
    logic          bwe_n, gw_n, oe_n;
    logic          wr_strobe, wr_q, rd_q, burst_load, burst_step, dq_oe;
    logic [5:0]    cyc_q;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    sram_cycle_decoder #(.NUM_BYTES(NB)) i_sram_cycle_decoder (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ce1_n(ce1_n),
        .ce2(ce2), .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .bw_n(bw_n), .bwe_n(bwe_n), .gw_n(gw_n), .oe_n(oe_n),
        .wr_strobe(wr_strobe), .cyc_q(cyc_q), .wr_q(wr_q), .rd_q(rd_q),
        .burst_load(burst_load), .burst_step(burst_step), .dq_oe(dq_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIM && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired act=%0d exp<=%0d", cycles, WD_LIM);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk = n_chk + 1;
        if (act !== expv) begin
            n_fail = n_fail + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    task automatic idle_pins();
        sleep_req = 0; ce1_n = 1; ce2 = 0; ce3_n = 1;
        adsp_n = 1; adsc_n = 1; adv_n = 1;
        bw_n = '1; bwe_n = 1; gw_n = 1; oe_n = 1;
    endtask

    initial begin
        idle_pins();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        // R10 reset state
        chk("R10 cyc", cyc_q, 6'b000001);
        chk("R10 flags", {wr_q, rd_q, burst_load, burst_step, dq_oe}, 0);
        @(negedge clk);
        rst_n = 1;

        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 2048; v++) begin
                logic sel, strobe, wreq, is_ct;
                int   k;
                logic e_wr, e_rd, e_ld, e_st;
                // Prep cycle: open (read begin) or close (deselect) the session.
                @(negedge clk);
                idle_pins();
                adsp_n = 0;
                if (s == 1) begin ce1_n = 0; ce2 = 1; ce3_n = 0; end
                // Stimulus cycle.
                @(negedge clk);
                sleep_req = v[0]; ce1_n = v[1]; ce2 = v[2]; ce3_n = v[3];
                adsp_n = v[4]; adsc_n = v[5]; adv_n = v[6];
                bw_n = v[8:7]; bwe_n = v[9]; gw_n = v[10];
                oe_n = 1;
                sel    = !ce1_n && ce2 && !ce3_n;
                strobe = !adsp_n || !adsc_n;
                wreq   = !gw_n || (!bwe_n && (bw_n != '1));
                #1;
                chk("R6 wr_strobe", wr_strobe, wreq);
                if (sleep_req)      k = 1;
                else if (strobe)    k = !sel ? 0 : (!adsp_n ? 2 : (wreq ? 3 : 2));
                else                k = !adv_n ? 4 : 5;
                is_ct = (k == 4) || (k == 5);
                e_ld = (k == 2) || (k == 3);
                e_wr = (k == 3) || (is_ct && s == 1 && wreq);
                e_rd = (k == 2) || (is_ct && s == 1 && !wreq);
                e_st = (k == 4) && s == 1;
                @(posedge clk);
                #(CLK_P/4);
                case (k)
                    0: chk("R2 deselect cyc", cyc_q, 6'b1 << k);
                    1: chk("R1 sleep cyc", cyc_q, 6'b1 << k);
                    2: chk(!adsp_n ? "R3 pstrobe read cyc" : "R5 cstrobe read cyc", cyc_q, 6'b1 << k);
                    3: chk("R4 write begin cyc", cyc_q, 6'b1 << k);
                    default: chk("R7 continue/suspend cyc", cyc_q, 6'b1 << k);
                endcase
                chk("R8 wr_q", wr_q, e_wr);
                chk("R8 rd_q", rd_q, e_rd);
                chk("R4 burst_load", burst_load, e_ld);
                chk("R7 burst_step", burst_step, e_st);
                chk("R11 onehot", $countones(cyc_q), 1);
                oe_n = 0; #1;
                chk("R9 dq_oe low oe", dq_oe, e_rd);
                oe_n = 1; #1;
                chk("R9 dq_oe high oe", dq_oe, 0);
            end
        end

        // R8 session kept across suspend: open, suspend, then a write beat.
        @(negedge clk);
        idle_pins(); ce1_n = 0; ce2 = 1; ce3_n = 0; adsc_n = 0; gw_n = 0;
        @(negedge clk);
        idle_pins();
        @(negedge clk);
        idle_pins(); adv_n = 0; bwe_n = 0; bw_n = 2'b10;
        @(posedge clk); #(CLK_P/4);
        chk("R8 write beat after suspend", {wr_q, rd_q, burst_step}, 3'b101);
        oe_n = 0; #1;
        chk("R9 masked in write", dq_oe, 0);

        // R1 sleep closes the session: next continuation moves nothing.
        @(negedge clk);
        idle_pins(); sleep_req = 1; adsp_n = 0; ce1_n = 0; ce2 = 1; ce3_n = 0;
        @(negedge clk);
        idle_pins(); adv_n = 0;
        @(posedge clk); #(CLK_P/4);
        chk("R1 session closed by sleep", {wr_q, rd_q, burst_step}, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule